// File: doc/BRIEF.md
# Per-Sector Volatile Write-Lock Register

This block keeps one volatile lock flag for every sector of a flash-style memory array. A decoded command port reaches those flags through a one-byte access value. A write opcode stores a flag, and a read opcode returns it as a full byte. The flag of a sector blocks program and erase operations to that sector. It never blocks reads.

A second, independent query port takes an address and an operation kind. It answers combinationally whether that operation must be inhibited. The memory controller sits beside this block and consults the answer before it starts a program or erase. The flags are not kept across resets: every reset loads every sector with a parameterised default, which is unlocked unless set otherwise. The sector index is the part of the address above a parameterised sector-size boundary.

Top module: `sector_lock_reg`

## Requirements
- R1: While reset is high at a clock edge, every sector flag takes the default value (unlocked, flag = 1, by default). After that edge, rd_valid is 0 and rd_byte is 8'h00.
- R2: A command with cmd_valid = 1, cmd_op = 8'hE1 and cmd_wdata = 8'h00 clears the addressed sector's flag to 0, which means locked.
- R3: A write command (8'hE1) with any cmd_wdata other than 8'h00 sets the flag to 1 (unlocked). Read-back of that sector then returns 8'hFF.
- R4: A command with cmd_valid = 1 and cmd_op = 8'hE0 makes rd_valid 1 in the next cycle. In that same cycle rd_byte is 8'h00 if the addressed sector is locked, or 8'hFF if it is unlocked. rd_byte never holds any other value.
- R5: In the cycle after any cycle without a valid read command, rd_valid is 0 and rd_byte keeps its previous value. A valid command with any opcode other than 8'hE0 or 8'hE1 leaves every flag unchanged.
- R6: The sector index is address bits [ADDR_W-1:SECTOR_SHIFT]. The lower bits do not matter. A write changes only the flag of its own sector.
- R7: q_inhibit is 1 exactly when q_kind is program (2'b10) or erase (2'b11) and the sector of q_addr is locked. It reflects the flag state in the same cycle.
- R8: q_inhibit is 0 when q_kind is read (2'b01) or none (2'b00), whatever the flag state.
- R9: A reset after any sequence of writes returns every sector to the default flag value.
- R10: A write opcode presented with cmd_valid = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_op | input | 8 | Decoded opcode (8'hE0 read, 8'hE1 write) |
| cmd_addr | input | ADDR_W | Byte address selecting the sector |
| cmd_wdata | input | 8 | Access byte to write |
| rd_valid | output | 1 | Read result valid for one cycle |
| rd_byte | output | 8 | Access byte read back (8'h00 or 8'hFF) |
| q_kind | input | 2 | Queried operation: 00 none, 01 read, 10 program, 11 erase |
| q_addr | input | ADDR_W | Queried address |
| q_inhibit | output | 1 | Operation must be blocked |

## Verification
The hardest case to reach from the ports is a single sector being locked while its neighbours stay unlocked. The test must show that the lock bites only for program and erase, including at the top sector index. The stimulus clears flags through addresses that carry non-zero low bits. It then reads back and queries the adjacent sectors and the same sector through differently offset addresses. After that it runs a long stream of pseudo-random writes, reads, stray opcodes and queries. A behavioural flag array is updated on every clock and checked against the outputs, and a final reset confirms that every flag is forgotten.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam logic [7:0] OP_RD_LOCK = 8'hE0;
  localparam logic [7:0] OP_WR_LOCK = 8'hE1;
  localparam logic [7:0] BYTE_LOCKED   = 8'h00;
  localparam logic [7:0] BYTE_UNLOCKED = 8'hFF;

  typedef enum logic [1:0] {
    QK_NONE  = 2'b00,
    QK_READ  = 2'b01,
    QK_PROG  = 2'b10,
    QK_ERASE = 2'b11
  } qkind_e;
endpackage

// File: rtl/slk_index.sv
module slk_index #(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_SHIFT = 16,
  localparam int IDX_W       = ADDR_W - SECTOR_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic unused_low;
  assign unused_low = ^addr[SECTOR_SHIFT-1:0];
  assign idx        = addr[ADDR_W-1:SECTOR_SHIFT];
endmodule

// File: rtl/slk_bits.sv
module slk_bits #(
  parameter int   IDX_W        = 8,
  parameter logic RESET_UNLOCK = 1'b1,
  localparam int  NSEC         = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  input  logic [IDX_W-1:0] ridx_a,
  output logic             rbit_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic             rbit_b
);
  logic [NSEC-1:0] flags;

  for (genvar s = 0; s < NSEC; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[s] <= RESET_UNLOCK;
      end else if (we && (widx == IDX_W'(s))) begin
        flags[s] <= wval;
      end
    end
  end

  assign rbit_a = flags[ridx_a];
  assign rbit_b = flags[ridx_b];
endmodule

// File: rtl/slk_query.sv
module slk_query
  import slk_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       unlocked,
  output logic       inhibit
);
  logic alters_array;
  always_comb begin
    unique case (qkind_e'(kind))
      QK_PROG, QK_ERASE: alters_array = 1'b1;
      default:           alters_array = 1'b0;
    endcase
  end
  assign inhibit = alters_array && !unlocked;
endmodule

// File: rtl/sector_lock_reg.sv
module sector_lock_reg
  import slk_pkg::*;
#(
  parameter int   ADDR_W       = 24,
  parameter int   SECTOR_SHIFT = 16,
  parameter logic RESET_UNLOCK = 1'b1,
  localparam int  IDX_W        = ADDR_W - SECTOR_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_byte,
  input  logic [1:0]        q_kind,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_inhibit
);
  logic [IDX_W-1:0] cmd_idx, q_idx;
  logic             cmd_bit, q_bit;
  logic             do_wr, do_rd;

  slk_index #(.ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT)) u_cmd_idx (
    .addr(cmd_addr), .idx(cmd_idx));
  slk_index #(.ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT)) u_q_idx (
    .addr(q_addr), .idx(q_idx));

  assign do_wr = cmd_valid && (cmd_op == OP_WR_LOCK);
  assign do_rd = cmd_valid && (cmd_op == OP_RD_LOCK);

  slk_bits #(.IDX_W(IDX_W), .RESET_UNLOCK(RESET_UNLOCK)) u_bits (
    .clk(clk), .rst(rst),
    .we(do_wr), .widx(cmd_idx), .wval(cmd_wdata != BYTE_LOCKED),
    .ridx_a(cmd_idx), .rbit_a(cmd_bit),
    .ridx_b(q_idx),   .rbit_b(q_bit));

  slk_query u_query (.kind(q_kind), .unlocked(q_bit), .inhibit(q_inhibit));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_byte  <= 8'h00;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_byte <= cmd_bit ? BYTE_UNLOCKED : BYTE_LOCKED;
    end
  end
endmodule

// File: rtl/slk_chk.sv
module slk_chk
  import slk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       rd_valid,
  input logic [7:0] rd_byte,
  input logic [1:0] q_kind,
  input logic       q_inhibit
);
  // R1
  rst_clears_read_chk: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_byte == 8'h00));

  // R4
  read_answers_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RD_LOCK) |=> rd_valid);

  // R4
  byte_coded_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_byte == BYTE_LOCKED || rd_byte == BYTE_UNLOCKED));

  // R5
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_RD_LOCK) |=> !rd_valid);

  // R5
  byte_held_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == OP_RD_LOCK) |=> $stable(rd_byte));

  // R8
  read_never_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (q_kind == QK_READ || q_kind == QK_NONE) |-> !q_inhibit);
endmodule

bind sector_lock_reg slk_chk u_slk_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_valid(rd_valid), .rd_byte(rd_byte), .q_kind(q_kind),
  .q_inhibit(q_inhibit));

// File: tb/sector_lock_reg_bench.sv
`timescale 1ns/1ps
module sector_lock_reg_bench;
  localparam int ADDR_W = 24;
  localparam int SHIFT  = 16;
  localparam int NSEC   = 1 << (ADDR_W - SHIFT);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_op = 8'h00;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0]        cmd_wdata = 8'h00;
  logic              rd_valid;
  logic [7:0]        rd_byte;
  logic [1:0]        q_kind = 2'b00;
  logic [ADDR_W-1:0] q_addr = '0;
  logic              q_inhibit;

  int checks = 0;
  int errors = 0;
  bit mdl [NSEC];
  bit exp_rv;
  logic [7:0] exp_rb;

  always #2 clk = ~clk;

  sector_lock_reg #(.ADDR_W(ADDR_W), .SECTOR_SHIFT(SHIFT)) u_sector_lock_reg (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .q_kind(q_kind), .q_addr(q_addr), .q_inhibit(q_inhibit));

  function automatic int sec(input logic [ADDR_W-1:0] a);
    return int'(a >> SHIFT);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    for (int s = 0; s < NSEC; s++) mdl[s] = 1'b1;
    exp_rv = 1'b0; exp_rb = 8'h00;
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs after reset
    chk("R1", rd_valid, 0);
    chk("R1", rd_byte, 8'h00);
  endtask

  // One cycle: drive at negedge, check query, advance model and DUT, check read port
  task automatic step(input bit v, input logic [7:0] op, input logic [ADDR_W-1:0] a,
                      input logic [7:0] wd, input logic [1:0] qk,
                      input logic [ADDR_W-1:0] qa);
    bit ex_inh;
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    q_kind = qk; q_addr = qa;
    #1;
    ex_inh = (qk[1] == 1'b1) && !mdl[sec(qa)];
    if (qk[1]) chk("R7", q_inhibit, ex_inh);
    else       chk("R8", q_inhibit, 0);
    exp_rv = 1'b0;
    if (v && op == 8'hE0) begin
      exp_rv = 1'b1;
      exp_rb = mdl[sec(a)] ? 8'hFF : 8'h00;
    end
    if (v && op == 8'hE1) mdl[sec(a)] = (wd != 8'h00);
    @(posedge clk);
    @(negedge clk);
    if (v && op == 8'hE0) begin
      chk("R4", rd_valid, 1);
      chk("R4", rd_byte, exp_rb);
    end else begin
      chk("R5", rd_valid, 0);
      chk("R5", rd_byte, exp_rb);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    step(1'b1, 8'hE0, a, 8'h00, 2'b00, a);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    step(1'b1, 8'hE1, a, d, 2'b00, a);
  endtask

  task automatic qry(input logic [1:0] k, input logic [ADDR_W-1:0] a);
    step(1'b0, 8'h00, '0, 8'h00, k, a);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: default unlocked
    rd(24'h00_0000);
    rd(24'hFF_FFFF);
    qry(2'b10, 24'h00_0010);
    // R2, R6: lock sector 5 through offset address, neighbours untouched
    wr(24'h05_1234, 8'h00);
    rd(24'h05_FFFF);
    rd(24'h04_FFFF);
    rd(24'h06_0000);
    // R7, R8: lock bites only program/erase
    qry(2'b10, 24'h05_0000);
    qry(2'b11, 24'h05_8000);
    qry(2'b01, 24'h05_0000);
    qry(2'b00, 24'h05_0000);
    qry(2'b11, 24'h06_0000);
    // R3: non-zero byte unlocks
    wr(24'h05_0001, 8'h5A);
    rd(24'h05_0000);
    qry(2'b10, 24'h05_0000);
    // top sector boundary
    wr(24'hFF_0000, 8'h00);
    rd(24'hFF_ABCD);
    qry(2'b11, 24'hFF_FFFF);
    // R5: stray opcode leaves flags alone
    step(1'b1, 8'h03, 24'h07_0000, 8'h00, 2'b10, 24'h07_0000);
    rd(24'h07_0000);
    // R10: write opcode without strobe ignored
    step(1'b0, 8'hE1, 24'h08_0000, 8'h00, 2'b11, 24'h08_0000);
    rd(24'h08_0000);
    qry(2'b11, 24'h08_0000);
    // mixed pseudo-random traffic over few sectors
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      logic [7:0] op;
      r = $urandom;
      case (r[1:0])
        2'd0: op = 8'hE0;
        2'd1: op = 8'hE1;
        2'd2: op = r[9] ? 8'hE1 : 8'hE0;
        default: op = r[15:8];
      endcase
      step(r[2] | r[3], op, {5'b0, r[6:4], r[31:16]}, r[7] ? 8'h00 : r[23:16],
           r[25:24], {5'b0, r[28:26], r[15:0]});
    end
    // R9: reset forgets all locks
    wr(24'h05_0000, 8'h00);
    do_reset();
    rd(24'h05_0000);
    rd(24'hFF_0000);
    qry(2'b10, 24'h05_0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule